// File: doc/BRIEF.md
# Streaming Frame Coefficient Scaler

This block multiplies every pixel of a stream of image frames by a scale factor. Pixels arrive on a byte-wide valid/ready data stream, and scale factors arrive on a separate byte-wide valid/ready coefficient stream. The scaled pixels leave on a byte-wide valid/ready output stream. Frame geometry is carried in-band: each frame opens with a two-byte header on the data stream that gives the number of lines and then the number of pixels in each line.

After the header, the block waits for one starting coefficient. It then passes exactly lines × pixels pixels through a truncating 8-bit multiplier. While the frame is in progress, the coefficient stream is polled rather than awaited. A coefficient that is offered is taken at once and applies to the pixel presented in the same cycle and to every later pixel. When no coefficient is offered, the pixel flow does not stall. After the final pixel the block raises a one-cycle completion pulse and returns to reading a header.

Top module: `frame_scaler`

## Requirements
- R1: In the header phase `din_ready` is 1. The first accepted data byte is the line count and the second is the pixels-per-line count, both unsigned 8-bit.
- R2: After the header, `din_ready` and `dout_valid` stay 0 until exactly one coefficient byte is accepted with `coef_ready` at 1.
- R3: A frame with nonzero dimensions yields exactly lines × pixels output bytes. Each output equals (pixel × coefficient) mod 256.
- R4: During the pixel phase, `dout_valid` follows `din_valid` and `din_ready` equals `dout_ready`. A pixel is taken only in the cycle its product is accepted.
- R5: During the pixel phase `coef_ready` is 1. A coefficient offered in the same cycle as a pixel is applied to that pixel and to all later pixels.
- R6: During the pixel phase, the absence of a coefficient never stalls the pixels. The last taken coefficient stays in use.
- R7: In the cycle after the last pixel of a frame is accepted, the block is back in the header phase: `din_ready` is 1 and `dout_valid` is 0.
- R8: A header with zero lines or zero pixels per line still takes one starting coefficient, then produces no output and returns directly to the header phase.
- R9: Synchronous active-high reset `rst` returns the block to the header phase, with `din_ready` 1, `coef_ready` 0, `dout_valid` 0 and `frame_done` 0. It also clears the counters and the held coefficient.
- R10: `frame_done` is 1 for exactly the one cycle in which the last pixel's product is accepted (`dout_valid` and `dout_ready` both 1), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din_data | input | 8 | Header byte or pixel byte |
| din_valid | input | 1 | Data stream valid |
| din_ready | output | 1 | Data stream ready |
| coef_data | input | 8 | Coefficient byte |
| coef_valid | input | 1 | Coefficient stream valid |
| coef_ready | output | 1 | Coefficient stream ready |
| dout_data | output | 8 | Scaled pixel |
| dout_valid | output | 1 | Output stream valid |
| dout_ready | input | 1 | Output stream ready |
| frame_done | output | 1 | One-cycle pulse on acceptance of a frame's last pixel |

## Verification
The assertions check the following on every cycle:
- The data and output handshakes stay tied together during the pixel phase.
- The completion pulse coincides with an accepted output and is followed by the header phase.
- Data and output stay blocked while the starting coefficient is awaited.
- Empty frames skip the pixel phase.
- The held coefficient changes only when one is taken.
- The pixel indices stay in range.

Only the bench scenarios can show that the products are numerically right, that the output count matches lines × pixels for every small geometry, and that a coefficient arriving alongside a pixel is applied to that very pixel. The bench sweeps all geometries from 0×0 to 3×3 with mid-frame coefficient changes and an irregular downstream ready.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    ST_LINES = 2'd0,
    ST_PPL   = 2'd1,
    ST_COEF  = 2'd2,
    ST_PIX   = 2'd3
  } fs_state_e;
endpackage

// File: rtl/fs_frame_counter.sv
module fs_frame_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_lines,
  input  logic          load_ppl,
  input  logic [CW-1:0] dim_in,
  input  logic          step,
  output logic          last,
  output logic          empty
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] lines_q, ppl_q, line_idx, pix_idx;
  logic          pix_wrap;

  assign pix_wrap = (pix_idx == ppl_q - ONE);
  assign last     = pix_wrap && (line_idx == lines_q - ONE);
  assign empty    = (lines_q == '0) || (ppl_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q  <= '0;
      ppl_q    <= '0;
      line_idx <= '0;
      pix_idx  <= '0;
    end else begin
      if (load_lines) lines_q <= dim_in;
      if (load_ppl) begin
        ppl_q    <= dim_in;
        line_idx <= '0;
        pix_idx  <= '0;
      end else if (step) begin
        if (pix_wrap) begin
          pix_idx  <= '0;
          line_idx <= line_idx + ONE;
        end else begin
          pix_idx <= pix_idx + ONE;
        end
      end
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    step |-> (!empty && pix_idx < ppl_q && line_idx < lines_q)) else $error("index range"); // R3
endmodule

// File: rtl/fs_coef_hold.sv
module fs_coef_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] coef_in,
  output logic [DW-1:0] coef_eff
);
  logic [DW-1:0] held;

  assign coef_eff = take ? coef_in : held;

  always_ff @(posedge clk) begin
    if (rst)       held <= '0;
    else if (take) held <= coef_in;
  end

  AST_COEF_KEPT: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(held)) else $error("coef changed untaken"); // R6
endmodule

// File: rtl/fs_scale_mul.sv
module fs_scale_mul #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] pix,
  input  logic [DW-1:0] coef,
  output logic [DW-1:0] prod
);
  assign prod = pix * coef;
endmodule

// File: rtl/frame_scaler.sv
module frame_scaler #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din_data,
  input  logic          din_valid,
  output logic          din_ready,
  input  logic [DW-1:0] coef_data,
  input  logic          coef_valid,
  output logic          coef_ready,
  output logic [DW-1:0] dout_data,
  output logic          dout_valid,
  input  logic          dout_ready,
  output logic          frame_done
);
  import fs_pkg::*;

  fs_state_e     st, st_nx;
  logic          in_hdr, pix_fire, coef_take, last, empty;
  logic [DW-1:0] coef_eff;

  assign in_hdr     = (st == ST_LINES) || (st == ST_PPL);
  assign din_ready  = in_hdr || ((st == ST_PIX) && dout_ready);
  assign coef_ready = (st == ST_COEF) || (st == ST_PIX);
  assign dout_valid = (st == ST_PIX) && din_valid;
  assign pix_fire   = dout_valid && dout_ready;
  assign coef_take  = coef_valid && coef_ready;
  assign frame_done = pix_fire && last;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_LINES: if (din_valid)  st_nx = ST_PPL;
      ST_PPL:   if (din_valid)  st_nx = ST_COEF;
      ST_COEF:  if (coef_valid) st_nx = empty ? ST_LINES : ST_PIX;
      ST_PIX:   if (frame_done) st_nx = ST_LINES;
      default:  st_nx = ST_LINES;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_LINES;
    else     st <= st_nx;
  end

  fs_frame_counter #(.CW(DW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_lines ((st == ST_LINES) && din_valid),
    .load_ppl   ((st == ST_PPL) && din_valid),
    .dim_in     (din_data),
    .step       (pix_fire),
    .last       (last),
    .empty      (empty)
  );

  fs_coef_hold #(.DW(DW)) u_coef (
    .clk      (clk),
    .rst      (rst),
    .take     (coef_take),
    .coef_in  (coef_data),
    .coef_eff (coef_eff)
  );

  fs_scale_mul #(.DW(DW)) u_mul (
    .pix  (din_data),
    .coef (coef_eff),
    .prod (dout_data)
  );

  AST_PIX_TIED_TO_OUT: assert property (@(posedge clk) disable iff (rst)
    (din_valid && din_ready && dout_valid) |-> dout_ready) else $error("pixel taken unaccepted"); // R4
  AST_DONE_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (dout_valid && dout_ready)) else $error("done without accept"); // R10
  AST_HDR_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (din_ready && !dout_valid && !coef_ready)) else $error("no header after done"); // R7
  AST_COEF_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COEF) |-> (!din_ready && !dout_valid)) else $error("data moved before coef"); // R2
  AST_EMPTY_SKIP: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COEF && coef_valid && empty) |=> (st == ST_LINES)) else $error("empty frame entered pixels"); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (st == ST_LINES && !dout_valid)) else $error("reset state"); // R9
endmodule

// File: tb/frame_scaler_test.sv
`timescale 1ns/1ps
module frame_scaler_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din_data = '0;
  logic       din_valid = 1'b0;
  logic       din_ready;
  logic [7:0] coef_data = '0;
  logic       coef_valid = 1'b0;
  logic       coef_ready;
  logic [7:0] dout_data;
  logic       dout_valid;
  logic       dout_ready = 1'b1;
  logic       frame_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #4 clk = ~clk;

  frame_scaler uut (
    .clk(clk), .rst(rst),
    .din_data(din_data), .din_valid(din_valid), .din_ready(din_ready),
    .coef_data(coef_data), .coef_valid(coef_valid), .coef_ready(coef_ready),
    .dout_data(dout_data), .dout_valid(dout_valid), .dout_ready(dout_ready),
    .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_data(input int v);
    din_data  = 8'(v);
    din_valid = 1'b1;
    #1;
    chk(din_ready === 1'b1 && dout_valid === 1'b0, "R1 header accept", int'(din_ready), 1);
    @(negedge clk);
    din_valid = 1'b0;
  endtask

  task automatic push_coef(input logic [7:0] c);
    coef_data  = c;
    coef_valid = 1'b1;
    #1;
    chk(coef_ready === 1'b1, "R2 start coef ready", int'(coef_ready), 1);
    @(negedge clk);
    coef_valid = 1'b0;
  endtask

  task automatic do_frame(input int lines, input int ppl, input logic [7:0] c0, input int mid);
    int n;
    logic [7:0] cur;
    n = lines * ppl;
    push_data(lines);
    push_data(ppl);
    din_valid = 1'b1;
    din_data  = 8'hAA;
    #1;
    chk(din_ready === 1'b0 && dout_valid === 1'b0, "R2 wait for coef", int'(din_ready), 0);
    @(negedge clk);
    din_valid = 1'b0;
    push_coef(c0);
    cur = c0;
    if (n == 0) begin
      din_valid = 1'b1;
      din_data  = 8'h00;
      #1;
      chk(din_ready === 1'b1 && dout_valid === 1'b0 && frame_done === 1'b0,
          "R8 empty frame back to header", int'(dout_valid), 0);
      din_valid = 1'b0;
      return;
    end
    for (int k = 0; k < n; k++) begin
      logic [7:0] pix;
      bit want, done;
      pix  = 8'(k * 37 + lines * 3 + ppl + 5);
      want = (mid > 0) && (k % mid == 1);
      din_valid = 1'b1;
      din_data  = pix;
      if (want) begin
        coef_valid = 1'b1;
        coef_data  = 8'(k * 11 + int'(c0));
      end
      done = 1'b0;
      while (!done) begin
        dout_ready = lfsr[0] | lfsr[1];
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        #1;
        if (coef_valid) begin
          chk(coef_ready === 1'b1, "R5 coef polled in pixel phase", int'(coef_ready), 1);
          cur = coef_data;
        end
        chk(dout_valid === 1'b1, "R4 valid follows pixel", int'(dout_valid), 1);
        chk(dout_data === 8'(int'(pix) * int'(cur)), want ? "R5 new coef applied" : "R3 R6 product",
            int'(dout_data), int'(pix) * int'(cur) % 256);
        chk(din_ready === dout_ready, "R4 ready tied", int'(din_ready), int'(dout_ready));
        chk(frame_done === (dout_ready && k == n - 1), "R10 done pulse",
            int'(frame_done), int'(dout_ready && k == n - 1));
        done = dout_ready;
        @(negedge clk);
        coef_valid = 1'b0;
      end
    end
    din_valid  = 1'b0;
    dout_ready = 1'b1;
    #1;
    chk(din_ready === 1'b1 && dout_valid === 1'b0 && frame_done === 1'b0,
        "R7 back to header", int'(din_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R7 actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(din_ready === 1'b1 && coef_ready === 1'b0 && dout_valid === 1'b0 && frame_done === 1'b0,
        "R9 reset outputs", int'(coef_ready), 0);
    @(negedge clk);
    rst = 1'b0;
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 4; p++)
        do_frame(l, p, 8'(l * 16 + p * 5 + 3), (l + p) % 3);
    do_frame(5, 7, 8'hFF, 2);
    do_frame(2, 3, 8'h81, 0);
    // reset in the middle of a frame
    push_data(2);
    push_data(2);
    push_coef(8'h09);
    din_valid  = 1'b1;
    din_data   = 8'h11;
    dout_ready = 1'b0;
    #1;
    chk(dout_valid === 1'b1 && dout_data === 8'h99, "R3 pending pixel", int'(dout_data), 8'h99);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk(din_ready === 1'b1 && coef_ready === 1'b0 && dout_valid === 1'b0,
        "R9 mid-frame reset", int'(dout_valid), 0);
    din_valid  = 1'b0;
    dout_ready = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    do_frame(1, 2, 8'h04, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule